// File: doc/BRIEF.md
# Byte-Wide Handshaked Link Port

This block moves whole words between two chips over an 8-bit point-to-point link. A mode input decides whether an instance transmits or receives. On the sending side a local write enters a 32-bit or 48-bit word. The port then puts that word on the byte bus one byte per cycle, lowest byte first, and marks each valid byte with a link clock pulse. On the receiving side the bytes are rebuilt into a word, and that word is offered on a local read interface with a valid/pop pair.

Each direction holds two words. The transmitter has a staging register and a shift register. The receiver has an assembly register and an output register. This lets a new word wait while the current one is in flight. The receiver drives an acknowledge line. The transmitter samples it only when it is about to begin a word, so flow control works per word and throughput stays at one byte per clock. Both ends are assumed to share one clock. The mode and size inputs are treated as static while words are in flight.

Top module: `linkport`

## Requirements
- R1: With `wide`=1 a word is 48 bits and takes 6 byte transfers; with `wide`=0 it is 32 bits and takes 4, and bits 47:32 of the read word are zero.
- R2: Bytes leave least significant first: transfer k of a word carries bits [8k+7:8k] on `lk_data_o`.
- R3: `lk_clk_o` is high for exactly one cycle per byte, the bytes of a word occupy consecutive cycles, and a staged word follows the previous one with no idle cycle.
- R4: The transmitter begins a word only in a cycle where `lk_ack_i` is high, and `lk_clk_o` stays low while it has nothing to send or is waiting for acknowledge.
- R5: The receiver drives `lk_ack_o` low exactly while a complete word sits in its assembly register and its output register is also occupied.
- R6: A write is accepted whenever the staging register is free or is being moved into the shift register in that cycle, so a second word can be queued behind one in flight.
- R7: A write that arrives while both transmit registers are occupied is dropped, and `wr_ovf` goes high and stays high until reset.
- R8: While `rd_valid` is high and `rd_en` is low, `rd_data` holds its value; received words are delivered in the order they were sent.
- R9: In receive mode (`is_tx`=0) local writes have no effect: `lk_clk_o` stays low and `wr_ovf` stays low.
- R10: After reset `lk_clk_o`=0, `wr_ovf`=0, `rd_valid`=0, and a receiver drives `lk_ack_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ends of the link |
| rst_n | input | 1 | Active-low synchronous reset |
| is_tx | input | 1 | 1 = transmit instance, 0 = receive instance |
| wide | input | 1 | 1 = 48-bit words, 0 = 32-bit words |
| wr_en | input | 1 | Local write strobe (transmit mode) |
| wr_data | input | WIDE_W | Word to send |
| wr_ovf | output | 1 | Sticky flag: a write was dropped |
| rd_valid | output | 1 | A received word is available |
| rd_data | output | WIDE_W | Received word |
| rd_en | input | 1 | Pops the received word |
| lk_clk_o | output | 1 | Link clock pulse, one per byte sent |
| lk_data_o | output | DW | Byte being sent |
| lk_ack_i | input | 1 | Acknowledge from the far receiver |
| lk_clk_i | input | 1 | Link clock pulse from the far sender |
| lk_data_i | input | DW | Byte being received |
| lk_ack_o | output | 1 | Acknowledge to the far sender |

## Verification
Two instances are wired back to back. A table of words is pushed through them in both sizes. The table includes all-ones, all-zeros, single-end-bit patterns, and words with distinct bytes. Distinct bytes expose any swap of byte order. Nonzero upper halves in 32-bit mode expose any leak of bits 47:32. The byte stream on the wire is also rebuilt and counted, which separates a wrong byte count or a gap from a wrong word. A burst of two queued words shows whether the staged word follows without a bubble. A blocked reader fills both receive registers, then both transmit registers, which shows whether acknowledge stalls the sender and whether the fifth word is dropped rather than overwriting a queued one.

// File: rtl/linkport.sv
module linkport #(
  parameter int DW       = 8,
  parameter int WIDE_W   = 48,
  parameter int NARROW_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_tx,
  input  logic              wide,
  input  logic              wr_en,
  input  logic [WIDE_W-1:0] wr_data,
  output logic              wr_ovf,
  output logic              rd_valid,
  output logic [WIDE_W-1:0] rd_data,
  input  logic              rd_en,
  output logic              lk_clk_o,
  output logic [DW-1:0]     lk_data_o,
  input  logic              lk_ack_i,
  input  logic              lk_clk_i,
  input  logic [DW-1:0]     lk_data_i,
  output logic              lk_ack_o
);
  localparam int NBW = WIDE_W / DW;
  localparam int NBN = NARROW_W / DW;
  localparam int CW  = $clog2(NBW);
  localparam logic [CW-1:0] LASTW = CW'(NBW - 1);
  localparam logic [CW-1:0] LASTN = CW'(NBN - 1);

  wire [CW-1:0]     last  = wide ? LASTW : LASTN;
  wire [WIDE_W-1:0] wmask = wide ? {WIDE_W{1'b1}}
                                 : {{(WIDE_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  // transmit side: staging register feeding a shift register
  logic              stg_v, sh_v, sh_go;
  logic [WIDE_W-1:0] stg_d, sh_d;
  logic [CW-1:0]     tcnt;

  assign lk_clk_o  = is_tx && sh_v && (sh_go || lk_ack_i);
  assign lk_data_o = lk_clk_o ? sh_d[DW-1:0] : '0;

  wire tx_end  = lk_clk_o && (tcnt == last);
  wire stg_mv  = stg_v && (!sh_v || tx_end);
  wire wr_ok   = is_tx && wr_en && (!stg_v || stg_mv);
  wire wr_drop = is_tx && wr_en && stg_v && !stg_mv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_v  <= 1'b0;
      sh_v   <= 1'b0;
      sh_go  <= 1'b0;
      tcnt   <= '0;
      stg_d  <= '0;
      sh_d   <= '0;
      wr_ovf <= 1'b0;
    end else begin
      if (wr_drop) wr_ovf <= 1'b1;
      if (wr_ok) begin
        stg_v <= 1'b1;
        stg_d <= wr_data & wmask;
      end else if (stg_mv) begin
        stg_v <= 1'b0;
      end
      if (stg_mv) begin
        sh_v  <= 1'b1;
        sh_go <= 1'b0;
        tcnt  <= '0;
        sh_d  <= stg_d;
      end else if (tx_end) begin
        sh_v  <= 1'b0;
        sh_go <= 1'b0;
        tcnt  <= '0;
      end else if (lk_clk_o) begin
        sh_go <= 1'b1;
        tcnt  <= tcnt + 1'b1;
        sh_d  <= sh_d >> DW;
      end
    end
  end

  // receive side: assembly register feeding an output register
  logic              asm_full, out_v;
  logic [WIDE_W-1:0] asm_d, out_d, asm_nx;
  logic [CW-1:0]     rcnt;

  wire rx_byte  = !is_tx && lk_clk_i;
  wire rx_end   = rx_byte && (rcnt == last);
  wire out_free = !out_v || rd_en;

  always_comb begin
    asm_nx = (rcnt == '0) ? '0 : asm_d;
    asm_nx[rcnt*DW +: DW] = lk_data_i;
  end

  assign rd_valid = out_v;
  assign rd_data  = out_d;
  assign lk_ack_o = !is_tx && !asm_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      asm_full <= 1'b0;
      out_v    <= 1'b0;
      asm_d    <= '0;
      out_d    <= '0;
      rcnt     <= '0;
    end else begin
      if (rx_byte) begin
        asm_d <= asm_nx;
        rcnt  <= rx_end ? '0 : rcnt + 1'b1;
      end
      if (rx_end && !out_free) asm_full <= 1'b1;
      else if (asm_full && out_free) asm_full <= 1'b0;
      if (rx_end && out_free) begin
        out_v <= 1'b1;
        out_d <= asm_nx;
      end else if (asm_full && out_free) begin
        out_v <= 1'b1;
        out_d <= asm_d;
      end else if (rd_en) begin
        out_v <= 1'b0;
      end
    end
  end

  AST_START_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    lk_clk_o && tcnt == '0 |-> lk_ack_i);                                    // R4
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !stg_v && !sh_v |=> !lk_clk_o);                                           // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    is_tx && wr_en && stg_v && sh_v && !tx_end |=> wr_ovf && stg_v && $stable(stg_d)); // R7
  AST_ACK_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    !is_tx && !lk_ack_o |-> out_v);                                           // R5
  AST_RX_NO_BYTE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    asm_full |-> !lk_clk_i);                                                  // R5
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_en |=> rd_valid && $stable(rd_data));                    // R8
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tcnt <= last && rcnt <= last);                                            // R1
endmodule

// File: tb/sim_linkport.sv
`timescale 1ns/1ps
module sim_linkport;
  localparam int W = 48;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, wide, wr_en, rd_en, w1_en;
  logic [W-1:0] wr_data;
  int checks = 0, fails = 0;

  wire          l_clk, l_ack;
  wire [7:0]    l_dat;
  wire          u0_rdv, u1_ovf, u1_clko, u0_acko;
  wire [W-1:0]  u0_rdd, u1_rdd;
  wire [7:0]    u1_dato;
  wire          u0_ovf, u1_rdv;

  linkport u0 (.clk(clk), .rst_n(rst_n), .is_tx(1'b1), .wide(wide),
    .wr_en(wr_en), .wr_data(wr_data), .wr_ovf(u0_ovf),
    .rd_valid(u0_rdv), .rd_data(u0_rdd), .rd_en(1'b0),
    .lk_clk_o(l_clk), .lk_data_o(l_dat), .lk_ack_i(l_ack),
    .lk_clk_i(1'b0), .lk_data_i(8'h00), .lk_ack_o(u0_acko));
  linkport u1 (.clk(clk), .rst_n(rst_n), .is_tx(1'b0), .wide(wide),
    .wr_en(w1_en), .wr_data(48'hABCD_EF01_2345), .wr_ovf(u1_ovf),
    .rd_valid(u1_rdv), .rd_data(u1_rdd), .rd_en(rd_en),
    .lk_clk_o(u1_clko), .lk_data_o(u1_dato), .lk_ack_i(1'b1),
    .lk_clk_i(l_clk), .lk_data_i(l_dat), .lk_ack_o(l_ack));

  // wire monitor: bytes seen and the cycle each was seen in
  int cyc = 0, nb = 0;
  logic [7:0] bytes [16];
  int stamp [16];
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && l_clk && nb < 16) begin
      bytes[nb] <= l_dat;
      stamp[nb] <= cyc;
      nb <= nb + 1;
    end
  end

  localparam logic [48:0] VEC [6] = '{
    {1'b1, 48'h0605_0403_0201}, {1'b0, 48'hFFFF_A1B2_C3D4},
    {1'b1, 48'hFFFF_FFFF_FFFF}, {1'b0, 48'h0000_0000_0000},
    {1'b1, 48'h8000_0000_0001}, {1'b0, 48'h1234_8765_4321}};

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [W-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic get(input string req, input logic [W-1:0] exp);
    int t = 0;
    @(negedge clk);
    while (!u1_rdv && t < 60) begin @(negedge clk); t++; end
    chk(req, u1_rdd, exp);
    rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  function automatic logic [W-1:0] from_wire(input int n);
    logic [W-1:0] v = '0;
    for (int k = 0; k < n; k++) v[k*8 +: 8] = bytes[k];
    return v;
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog actual=%0d expected<%0d", 20000, 20000);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wide = 1'b1; wr_en = 1'b0; rd_en = 1'b0; w1_en = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 lk_clk_o", W'(l_clk), 48'd0);
    chk("R10 wr_ovf", W'(u0_ovf), 48'd0);
    chk("R10 rd_valid", W'(u1_rdv), 48'd0);
    chk("R10 lk_ack_o", W'(l_ack), 48'd1);

    // table walk
    for (int i = 0; i < 6; i++) begin
      logic [W-1:0] exp;
      int n;
      wide = VEC[i][48];
      n    = wide ? 6 : 4;
      exp  = wide ? VEC[i][47:0] : {16'h0, VEC[i][31:0]};
      @(negedge clk); nb = 0;
      put(VEC[i][47:0]);
      get("R1 R8 word", exp);
      chk("R1 byte count", W'(nb), W'(n));
      chk("R2 wire order", from_wire(n), exp);
      chk("R3 consecutive", W'(stamp[n-1] - stamp[0]), W'(n - 1));
    end

    // back-to-back words: staged word follows with no bubble
    wide = 1'b0;
    @(negedge clk); nb = 0;
    put(48'h0000_1111_2222);
    put(48'h0000_3333_4444);
    repeat (20) @(negedge clk);
    chk("R3 R6 burst bytes", W'(nb), 48'd8);
    chk("R3 R6 burst span", W'(stamp[7] - stamp[0]), 48'd7);
    get("R8 order first", 48'h0000_1111_2222);
    get("R8 order second", 48'h0000_3333_4444);

    // backpressure and overflow
    put(48'h0000_0000_00A1); repeat (20) @(negedge clk);
    put(48'h0000_0000_00A2); repeat (20) @(negedge clk);
    chk("R5 ack low when full", W'(l_ack), 48'd0);
    put(48'h0000_0000_00A3);
    @(negedge clk); nb = 0;
    repeat (12) @(negedge clk);
    chk("R4 no link clock without ack", W'(nb), 48'd0);
    put(48'h0000_0000_00A4); repeat (4) @(negedge clk);
    chk("R6 queued write accepted", W'(u0_ovf), 48'd0);
    put(48'h0000_0000_00A5); repeat (2) @(negedge clk);
    chk("R7 overflow flagged", W'(u0_ovf), 48'd1);
    get("R7 R8 keep A1", 48'h0000_0000_00A1);
    chk("R5 ack restored", W'(l_ack), 48'd1);
    get("R7 R8 keep A2", 48'h0000_0000_00A2);
    get("R7 R8 keep A3", 48'h0000_0000_00A3);
    get("R7 R8 keep A4", 48'h0000_0000_00A4);
    repeat (30) @(negedge clk);
    chk("R7 dropped word absent", W'(u1_rdv), 48'd0);
    chk("R7 overflow sticky", W'(u0_ovf), 48'd1);

    // receive-mode writes have no effect
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); w1_en = 1'b1;
      @(negedge clk); w1_en = 1'b0;
      chk("R9 rx lk_clk_o", W'(u1_clko), 48'd0);
    end
    repeat (10) @(negedge clk);
    chk("R9 rx lk_clk_o later", W'(u1_clko), 48'd0);
    chk("R9 rx wr_ovf", W'(u1_ovf), 48'd0);

    // reset clears the sticky flag
    rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk("R10 wr_ovf cleared", W'(u0_ovf), 48'd0);
    chk("R10 ack after reset", W'(l_ack), 48'd1);
    finish_run();
  end
endmodule